// File: doc/BRIEF.md
# Transmitter Slew-Rate Calibration Sequencer

This block is a hardware sequencer that tunes the slew rate of a high-speed serial transmitter once the port has been powered up. It starts a ring oscillator and lets it settle. It then turns on a free-running clock and sets the measurement window of an external frequency meter to 1024 cycles. After that it enables the meter and polls the meter's valid flag at a fixed interval. The poll ends when the flag is seen or when a time limit has passed. In both cases the meter count is captured and used, because a missed flag is not an error.

With the count captured, the block switches the meter off and then the free-running clock. It divides a constant by the count using a sequential divider and rounds the result to a 3-bit slew code. It publishes that code while the oscillator is still running, then drops the oscillator and pulses done. If a nonzero override code is present at start, measurement is skipped entirely and the override is published at once. A zero count selects a fixed fallback code.

All delays are counted in microsecond ticks, derived from the system clock by a parameterised divider. The reference frequency and the coefficient are parameters, with defaults of 26 MHz and 17.

Top module: `srcal_seq`

## Requirements
- R1: After reset, osc_en_o, frck_en_o, meter_en_o, done_o, code_o and meter_cycles_o are all zero.
- R2: A start with a nonzero force_code_i never raises osc_en_o, frck_en_o or meter_en_o. In the cycle after start is sampled, code_o equals the override and done_o is high.
- R3: A start with force_code_i of zero raises osc_en_o first. frck_en_o follows no sooner than SETTLE_US microseconds later, and meter_en_o comes after that. While meter_en_o is high, meter_cycles_o reads METER_CYC (1024) and both enables are high.
- R4: While the meter runs, meter_valid_i is sampled once on entry and then every POLL_US microseconds. The count is captured at the first sample that finds the flag high, so meter_en_o falls within POLL_US microseconds plus a few cycles of the flag's rise.
- R5: If the flag never rises, the count present once TIMEOUT_US microseconds have elapsed is captured and used like a valid result.
- R6: Teardown order is fixed. meter_en_o falls first, frck_en_o falls in a later cycle, and osc_en_o falls after that. The captured count is unaffected by later changes on meter_count_i.
- R7: For a nonzero count C, the code equals floor((floor(REF_MHZ*COEF*1024 / C) + 500) / 1000).
- R8: A captured count of zero yields the code DEFAULT_CODE (3).
- R9: A computed code above 7 is clamped to 7.
- R10: code_o takes its final value while osc_en_o is still high. done_o is high for exactly one cycle, in the cycle where osc_en_o first reads low, and code_o then holds until the next start.
- R11: start_i is ignored while a calibration is in progress, and a run ends with the block idle (all enables low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a calibration (sampled when idle) |
| force_code_i | input | CODE_W | Override code; nonzero skips measurement |
| meter_valid_i | input | 1 | Frequency meter result valid |
| meter_count_i | input | CNT_W | Frequency meter count |
| osc_en_o | output | 1 | Ring oscillator enable |
| frck_en_o | output | 1 | Free-running clock enable |
| meter_en_o | output | 1 | Frequency meter enable |
| meter_cycles_o | output | CYC_W | Measurement window length for the meter |
| code_o | output | CODE_W | Slew-rate code driven to the transmitter |
| done_o | output | 1 | One-cycle pulse when the code is final |

## Verification
Some properties are checked in every cycle. The meter only runs while both clocks run. The free-running clock stops only after the meter has stopped. done is a lone pulse with every enable low. The code never changes outside the oscillator-on window or the done cycle. Inside the divider, start leads to busy, and done follows busy. The tick generator never fires on two cycles in a row. Only bench scenarios can show the arithmetic and the timing: the rounding boundaries, the zero fallback, the clamp, the settle and poll spacing, the timeout capture, the override bypass and the ignored restart.

// File: rtl/srcal_pkg.sv
package srcal_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_FORCE,
    S_SETTLE,
    S_FRCK,
    S_CFG,
    S_POLL,
    S_MDIS,
    S_FDIS,
    S_DIV,
    S_DWAIT,
    S_WRITE,
    S_OFF
  } srcal_state_e;
endpackage

// File: rtl/srcal_tick.sv
module srcal_tick #(
  parameter int CLK_PER_US = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic tick_o
);
  generate
    if (CLK_PER_US <= 1) begin : g_pass
      assign tick_o = en_i;
    end else begin : g_cnt
      localparam int CW = $clog2(CLK_PER_US);
      localparam logic [CW-1:0] CMAX = CW'(CLK_PER_US - 1);
      logic [CW-1:0] cnt_q, cnt_d;

      assign tick_o = en_i && (cnt_q == CMAX);

      always_comb begin
        cnt_d = cnt_q;
        if (!en_i || tick_o) cnt_d = '0;
        else                 cnt_d = cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      // R3: microsecond ticks are spaced, never back to back
      assert_tick_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/srcal_div.sv
module srcal_div #(
  parameter int NUM_W = 19,
  parameter int DEN_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [NUM_W-1:0] quo_o
);
  localparam int IT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] quo_q, quo_d;
  logic [DEN_W-1:0] rem_q, rem_d;
  logic [IT_W-1:0]  it_q, it_d;
  logic             busy_q, busy_d, done_q, done_d;
  logic [DEN_W:0]   rem_sh, rem_sub;
  logic             fits;

  assign rem_sh  = {rem_q, quo_q[NUM_W-1]};
  assign fits    = rem_sh >= {1'b0, den_i};
  assign rem_sub = rem_sh - {1'b0, den_i};

  always_comb begin
    quo_d  = quo_q;
    rem_d  = rem_q;
    it_d   = it_q;
    busy_d = busy_q;
    done_d = 1'b0;
    if (start_i) begin
      quo_d  = num_i;
      rem_d  = '0;
      it_d   = IT_W'(NUM_W);
      busy_d = 1'b1;
    end else if (busy_q) begin
      quo_d = {quo_q[NUM_W-2:0], fits};
      rem_d = fits ? rem_sub[DEN_W-1:0] : rem_sh[DEN_W-1:0];
      it_d  = it_q - 1'b1;
      if (it_q == IT_W'(1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q  <= '0;
      rem_q  <= '0;
      it_q   <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      quo_q  <= quo_d;
      rem_q  <= rem_d;
      it_q   <= it_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign quo_o  = quo_q;

  // R7: a launched division is in progress on the following cycle
  assert_div_launch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> busy_o);
  // R7: completion only ever follows a busy cycle
  assert_div_finish_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o && $past(busy_o));
endmodule

// File: rtl/srcal_seq.sv
module srcal_seq
  import srcal_pkg::*;
#(
  parameter int CLK_PER_US   = 200,
  parameter int SETTLE_US    = 1,
  parameter int POLL_US      = 10,
  parameter int TIMEOUT_US   = 200,
  parameter int REF_MHZ      = 26,
  parameter int COEF         = 17,
  parameter int METER_CYC    = 1024,
  parameter int SCALE        = 1000,
  parameter int CYC_W        = 24,
  parameter int CNT_W        = 24,
  parameter int CODE_W       = 3,
  parameter int DEFAULT_CODE = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CODE_W-1:0] force_code_i,
  input  logic              meter_valid_i,
  input  logic [CNT_W-1:0]  meter_count_i,
  output logic              osc_en_o,
  output logic              frck_en_o,
  output logic              meter_en_o,
  output logic [CYC_W-1:0]  meter_cycles_o,
  output logic [CODE_W-1:0] code_o,
  output logic              done_o
);
  localparam int NUMER = REF_MHZ * COEF * METER_CYC;
  localparam int NUM_W = $clog2(NUMER + 1);
  localparam int US_W  = $clog2(TIMEOUT_US + POLL_US + SETTLE_US + 2);
  localparam int PT_W  = (POLL_US > 1) ? $clog2(POLL_US) : 1;
  localparam int NCODE = (1 << CODE_W) - 1;

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rsync_q;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sn = rsync_q[1];

  srcal_state_e      state_q, state_d;
  logic [US_W-1:0]   us_q, us_d;
  logic [PT_W-1:0]   pt_q, pt_d;
  logic              chk_q, chk_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CODE_W-1:0] code_q, code_d;

  logic              tick_en, us_tick;
  logic              div_go, div_busy, div_done;
  logic [NUM_W-1:0]  div_quo;
  logic [NCODE-1:0]  above;
  logic [CODE_W-1:0] code_calc;

  assign tick_en = (state_q == S_SETTLE) || (state_q == S_POLL);
  assign div_go  = (state_q == S_DIV);

  srcal_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk    (clk),
    .rst_n  (rst_sn),
    .en_i   (tick_en),
    .tick_o (us_tick)
  );

  srcal_div #(.NUM_W(NUM_W), .DEN_W(CNT_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_sn),
    .start_i (div_go),
    .num_i   (NUM_W'(NUMER)),
    .den_i   (cnt_q),
    .busy_o  (div_busy),
    .done_o  (div_done),
    .quo_o   (div_quo)
  );

  // round to nearest multiple of SCALE, saturating at NCODE
  genvar g;
  generate
    for (g = 0; g < NCODE; g++) begin : g_thr
      localparam longint unsigned THR = longint'(SCALE) * (g + 1) - SCALE / 2;
      assign above[g] = 64'(div_quo) >= THR;
    end
  endgenerate
  assign code_calc = CODE_W'($countones(above));

  always_comb begin
    state_d = state_q;
    us_d    = us_q;
    pt_d    = pt_q;
    chk_d   = chk_q;
    cnt_d   = cnt_q;
    code_d  = code_q;
    unique case (state_q)
      S_IDLE: begin
        us_d = '0;
        if (start_i) begin
          if (force_code_i != '0) begin
            code_d  = force_code_i;
            state_d = S_FORCE;
          end else begin
            state_d = S_SETTLE;
          end
        end
      end
      S_FORCE: state_d = S_IDLE;
      S_SETTLE: begin
        if (us_tick) us_d = us_q + 1'b1;
        if (us_q >= US_W'(SETTLE_US)) begin
          us_d    = '0;
          state_d = S_FRCK;
        end
      end
      S_FRCK: state_d = S_CFG;
      S_CFG: begin
        us_d    = '0;
        pt_d    = '0;
        chk_d   = 1'b1;
        state_d = S_POLL;
      end
      S_POLL: begin
        chk_d = us_tick && (pt_q == PT_W'(POLL_US - 1));
        if (us_tick) begin
          us_d = us_q + 1'b1;
          pt_d = (pt_q == PT_W'(POLL_US - 1)) ? '0 : pt_q + 1'b1;
        end
        if (chk_q && (meter_valid_i || us_q >= US_W'(TIMEOUT_US))) begin
          cnt_d   = meter_count_i;
          state_d = S_MDIS;
        end
      end
      S_MDIS: state_d = S_FDIS;
      S_FDIS: begin
        if (cnt_q == '0) begin
          code_d  = CODE_W'(DEFAULT_CODE);
          state_d = S_WRITE;
        end else begin
          state_d = S_DIV;
        end
      end
      S_DIV: state_d = S_DWAIT;
      S_DWAIT: begin
        if (div_done) begin
          code_d  = code_calc;
          state_d = S_WRITE;
        end
      end
      S_WRITE: state_d = S_OFF;
      S_OFF:   state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= S_IDLE;
      us_q    <= '0;
      pt_q    <= '0;
      chk_q   <= 1'b0;
      cnt_q   <= '0;
      code_q  <= '0;
    end else begin
      state_q <= state_d;
      us_q    <= us_d;
      pt_q    <= pt_d;
      chk_q   <= chk_d;
      cnt_q   <= cnt_d;
      code_q  <= code_d;
    end
  end

  assign osc_en_o  = !(state_q inside {S_IDLE, S_FORCE, S_OFF});
  assign frck_en_o = state_q inside {S_FRCK, S_CFG, S_POLL, S_MDIS};
  assign meter_en_o = (state_q == S_POLL);
  assign meter_cycles_o = (state_q inside {S_CFG, S_POLL}) ? CYC_W'(METER_CYC) : '0;
  assign code_o = code_q;
  assign done_o = (state_q == S_FORCE) || (state_q == S_OFF);

  // R3: the meter only runs with oscillator and free-running clock on
  assert_meter_clocks_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    meter_en_o |-> frck_en_o && osc_en_o && (meter_cycles_o == CYC_W'(METER_CYC)));
  // R6: free-running clock stops only after the meter already stopped
  assert_teardown_order_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    $fell(frck_en_o) |-> !meter_en_o && $past(!meter_en_o));
  // R10: done arrives with every enable low
  assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!rst_sn)
    done_o |-> !osc_en_o && !frck_en_o && !meter_en_o);
  // R10: done is a single-cycle pulse
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_sn)
    done_o |=> !done_o);
  // R10: the code moves only while the oscillator runs or at done
  assert_code_window_R10: assert property (@(posedge clk) disable iff (!rst_sn)
    !$stable(code_o) |-> osc_en_o || done_o);
endmodule

// File: tb/srcal_seq_test.sv
`timescale 1ns/1ps
module srcal_seq_test;
  localparam int CPU = 4;
  localparam int SET = 1;
  localparam int POL = 10;
  localparam int TMO = 200;
  localparam int NUMER_TB = 26 * 17 * 1024;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [2:0]  force_code_i;
  logic        meter_valid_i;
  logic [23:0] meter_count_i;
  logic        osc_en_o, frck_en_o, meter_en_o, done_o;
  logic [23:0] meter_cycles_o;
  logic [2:0]  code_o;

  int nchk = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;

  srcal_seq #(.CLK_PER_US(CPU), .SETTLE_US(SET), .POLL_US(POL), .TIMEOUT_US(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .force_code_i(force_code_i),
    .meter_valid_i(meter_valid_i), .meter_count_i(meter_count_i),
    .osc_en_o(osc_en_o), .frck_en_o(frck_en_o), .meter_en_o(meter_en_o),
    .meter_cycles_o(meter_cycles_o), .code_o(code_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_code(input logic [23:0] c);
    int q, r;
    if (c == 0) return 3;           // R8
    q = NUMER_TB / int'(c);
    r = (q + 500) / 1000;           // R7
    if (r > 7) r = 7;               // R9
    return r;
  endfunction

  task automatic run_cal(input logic [2:0] frc, input logic [23:0] cnt,
                         input int vdly, input bit poke);
    int t = 0;
    int t_osc = -1, t_frck = -1, t_men = -1, t_mfall = -1;
    int t_ffall = -1, t_ofall = -1, t_done = -1;
    bit p_osc = 0, p_frck = 0, p_men = 0;
    int expv;
    logic [2:0] code_on = '0;
    logic [2:0] fin;
    expv = (frc != 0) ? int'(frc) : exp_code(cnt);
    force_code_i  = frc;
    meter_count_i = cnt;
    meter_valid_i = 1'b0;
    start_i       = 1'b1;
    while (t < 4000 && t_done < 0) begin
      @(negedge clk);
      t++;
      if (t == 1) start_i = 1'b0;
      if (poke && t == 20) begin start_i = 1'b1; force_code_i = 3'd5; end
      if (poke && t == 21) begin start_i = 1'b0; force_code_i = frc; end
      if (osc_en_o) code_on = code_o;
      if (osc_en_o && !p_osc) t_osc = t;
      if (!osc_en_o && p_osc) t_ofall = t;
      if (frck_en_o && !p_frck) t_frck = t;
      if (!frck_en_o && p_frck) t_ffall = t;
      if (meter_en_o && !p_men) begin
        t_men = t;
        chk(meter_cycles_o == 24'd1024, "R3 window length", meter_cycles_o, 1024);
      end
      if (!meter_en_o && p_men) begin
        t_mfall = t;
        meter_count_i = ~cnt;       // R6: must not disturb the captured count
        meter_valid_i = 1'b0;
      end
      if (t_men >= 0 && t_mfall < 0 && vdly >= 0 && (t - t_men) >= vdly)
        meter_valid_i = 1'b1;
      if (done_o) t_done = t;
      p_osc = osc_en_o; p_frck = frck_en_o; p_men = meter_en_o;
    end
    chk(t_done > 0, "R10 done seen", t_done, 1);
    fin = code_o;
    chk(int'(fin) == expv, (frc != 0) ? "R2 forced code" : "R7/R8/R9 code value", fin, expv);
    if (frc != 0) begin
      chk(t_osc < 0 && t_frck < 0 && t_men < 0, "R2 no measurement", t_osc, -1);
      chk(t_done == 1, "R2 done timing", t_done, 1);
    end else begin
      chk(t_osc > 0 && t_frck - t_osc >= CPU * SET, "R3 settle gap", t_frck - t_osc, CPU * SET);
      chk(t_men > t_frck, "R3 meter after clock", t_men, t_frck + 1);
      chk(t_mfall > t_men && t_ffall > t_mfall && t_ofall > t_ffall,
          "R6 teardown order", t_ffall - t_mfall, 1);
      chk(t_ofall == t_done, "R10 done with osc low", t_done, t_ofall);
      chk(code_on == fin, "R10 code set while osc on", code_on, fin);
      if (vdly >= 0)
        chk(t_mfall - t_men >= vdly && t_mfall - t_men <= vdly + POL * CPU + 4,
            "R4 poll capture delay", t_mfall - t_men, vdly);
      else
        chk(t_mfall - t_men >= TMO * CPU, "R5 timeout wait", t_mfall - t_men, TMO * CPU);
    end
    @(negedge clk);
    chk(!done_o, "R10 single pulse", done_o, 0);
    repeat (3) @(negedge clk);
    chk(code_o == fin, "R10 code held", code_o, fin);
    chk(!osc_en_o && !frck_en_o && !meter_en_o, "R11 idle after run", osc_en_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start_i = 1'b0; force_code_i = '0;
    meter_valid_i = 1'b0; meter_count_i = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(!osc_en_o && !frck_en_o && !meter_en_o && !done_o, "R1 enables low", osc_en_o, 0);
    chk(code_o == 0 && meter_cycles_o == 0, "R1 code and window zero", code_o, 0);

    run_cal(3'd0, 24'd905, 30, 1'b0);       // R7 q=500 rounds up to 1
    run_cal(3'd0, 24'd906, 5, 1'b0);        // R7 q=499 rounds down to 0
    run_cal(3'd0, 24'd301, 0, 1'b0);        // R7 q=1503 -> 2
    run_cal(3'd0, 24'd302, 77, 1'b0);       // R7 q=1498 -> 1
    run_cal(3'd0, 24'd0, 12, 1'b0);         // R8 zero count
    run_cal(3'd0, 24'd1, 3, 1'b0);          // R9 huge quotient clamps
    run_cal(3'd0, 24'd60, 3, 1'b0);         // R9 rounds to 8, clamps
    run_cal(3'd0, 24'hFFFFFF, 3, 1'b0);     // R7 tiny quotient
    run_cal(3'd5, 24'd100, 3, 1'b0);        // R2 override
    run_cal(3'd7, 24'd0, 3, 1'b0);          // R2 override
    run_cal(3'd0, 24'd452, -1, 1'b0);       // R5 timeout, q=1001 -> 1
    run_cal(3'd0, 24'd150, 40, 1'b1);       // R11 restart ignored, -> 3

    for (int i = 0; i < 12; i++) begin
      logic [23:0] c;
      int d;
      c = 24'(30 + ($urandom % 3000));
      d = int'($urandom % 150);
      run_cal(3'd0, c, d, 1'b0);            // R4/R7 random
    end

    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule